// File: doc/BRIEF.md
# Two-Phase Frame Ring Pointer Manager

This block keeps the four pointers of a circular buffer of 32-byte frames. A producer and a consumer share the buffer. The producer side has an allocated write pointer and a committed write pointer. Space can therefore be reserved in 16-frame multiframe steps and made visible later, once it has been filled. The consumer side has a peeked read pointer and a discarded read pointer. A multiframe can therefore be handed out for reading and still be held until the consumer releases it.

One command is accepted per cycle. Commands are:

- frame runs of a requested length, for writing or for reading;
- multiframe reserve, commit, look and release;
- two flushes that realign the pointers to multiframe boundaries.

Every accepted command gets a registered response one cycle later. The response says whether the command was granted, how many frames it covers, and where they sit. The location is given three ways: a frame offset (a base parameter plus the ring pointer), a multiframe index and a 32-bit word address. The four occupancy levels are driven continuously from the pointer registers. The frame memory and any copy engine sit outside this block.

Top module: `frame_ring_ptr`

## Requirements
- R1: While the reset is asserted, and right after it is released, all four pointers are zero. The levels then read allocated 0, valid 0, unseen 0 and free RING_FRAMES-1, and rsp_valid is low.
- R2: All levels are computed modulo RING_FRAMES:
  - allocated = allocated write minus discarded read;
  - valid = committed write minus discarded read;
  - unseen = committed write minus peeked read.
- R3: free = discarded read minus allocated write minus 1, so free + allocated always equals RING_FRAMES-1. Any write or reserve command is refused when free is too small.
- R4: A command is taken on a clock edge with cmd_valid high. Its response appears after that edge, with rsp_valid high for one cycle. The cmd_op codes are:
  - 0 = write run;
  - 1 = read run;
  - 2 = reserve;
  - 3 = commit;
  - 4 = look;
  - 5 = release;
  - 6 = flush to tail;
  - 7 = flush to head.

  On a granted command, rsp_ofs = BASE_OFS + pointer, rsp_mf_idx = rsp_ofs >> 4 and rsp_word_addr = rsp_ofs << 3.
- R5: Reserve is granted only when free >= 16. It returns the allocated pointer and advances it by 16. Commit is granted only when (allocated - committed) >= 16. It returns the committed pointer and advances it by 16. Both report 16 frames.
- R6: Look is granted only when unseen >= 16. It returns the peeked pointer and advances it by 16. Release is granted only when (peeked - discarded) >= 16. It returns the discarded pointer and advances it by 16. Both report 16 frames.
- R7: A write run grants min(requested, free, RING_FRAMES - committed pointer) frames. It returns the committed pointer and moves both write pointers to committed + grant. A read run does the same with unseen and the peeked pointer, and moves both read pointers.
- R8: A frame run is refused when its pointer pair is split (a reservation or a look is outstanding), or when the grant would be zero.
- R9: Flush to tail sets both read pointers to the committed write pointer rounded down to a multiple of 16. It reports that pointer and 0 frames.
- R10: Flush to head sets both write pointers to the peeked read pointer rounded up to a multiple of 16, modulo the ring size. It reports that pointer and 0 frames.
- R11: A refused command gives rsp_ok = 0, rsp_frames = 0 and rsp_ofs = 0, and changes no pointer.
- R12: With cmd_valid low, nothing changes and no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R4) |
| cmd_frames | input | CNT_W (9) | Requested frame count for runs |
| rsp_valid | output | 1 | Response for the command of the previous edge |
| rsp_ok | output | 1 | Command granted |
| rsp_frames | output | CNT_W (9) | Frames granted |
| rsp_ofs | output | OFS_W (10) | Frame offset |
| rsp_mf_idx | output | OFS_W-4 (6) | Multiframe index |
| rsp_word_addr | output | OFS_W+3 (13) | 32-bit word address |
| lvl_alloc | output | PTR_W (8) | Allocated frames |
| lvl_valid | output | PTR_W (8) | Committed, not yet released frames |
| lvl_unseen | output | PTR_W (8) | Committed, not yet looked-at frames |
| lvl_free | output | PTR_W (8) | Frames open to reservation |

## Verification
The hardest state to reach is a ring that is full to the last slot. Free must be zero while the committed write pointer sits just behind the peeked read pointer, so that unseen reads RING_FRAMES-1 and refusals of reserve and write can be observed. The stimulus gets there in two steps. A long write run is first clamped by the end of the ring. A second run is then clamped by the free count, which fills the last free slot. From that state, both flush commands are applied to aligned and unaligned pointers, which exercises rounding up and rounding down.

// File: rtl/frame_ring_pkg.sv
package frame_ring_pkg;
  typedef enum logic [2:0] {
    OP_WR_RUN   = 3'd0,
    OP_RD_RUN   = 3'd1,
    OP_MF_RSV   = 3'd2,
    OP_MF_CMT   = 3'd3,
    OP_MF_LOOK  = 3'd4,
    OP_MF_REL   = 3'd5,
    OP_FL_TAIL  = 3'd6,
    OP_FL_HEAD  = 3'd7
  } ring_op_e;
endpackage

// File: rtl/frame_ring_levels.sv
module frame_ring_levels #(
  parameter int PTR_W = 8
) (
  input  logic [PTR_W-1:0] wr_cmt,
  input  logic [PTR_W-1:0] wr_alc,
  input  logic [PTR_W-1:0] rd_pk,
  input  logic [PTR_W-1:0] rd_dis,
  output logic [PTR_W-1:0] lv_alloc,
  output logic [PTR_W-1:0] lv_valid,
  output logic [PTR_W-1:0] lv_unseen,
  output logic [PTR_W-1:0] lv_free,
  output logic [PTR_W-1:0] wr_pend,
  output logic [PTR_W-1:0] rd_pend
);
  // modulo arithmetic comes from the natural PTR_W-bit wrap
  always_comb begin
    lv_alloc  = wr_alc - rd_dis;
    lv_valid  = wr_cmt - rd_dis;
    lv_unseen = wr_cmt - rd_pk;
    lv_free   = rd_dis - wr_alc - PTR_W'(1);
    wr_pend   = wr_alc - wr_cmt;
    rd_pend   = rd_pk - rd_dis;
  end
endmodule

// File: rtl/frame_ring_clamp.sv
module frame_ring_clamp #(
  parameter int PTR_W = 8,
  localparam int CNT_W = PTR_W + 1
) (
  input  logic [CNT_W-1:0] req,
  input  logic [PTR_W-1:0] avail,
  input  logic [PTR_W-1:0] ptr,
  output logic [CNT_W-1:0] grant
);
  logic [CNT_W-1:0] to_end;
  logic [CNT_W-1:0] avail_w;
  logic [CNT_W-1:0] lim;

  always_comb begin
    to_end  = CNT_W'(1 << PTR_W) - {1'b0, ptr};
    avail_w = {1'b0, avail};
    lim     = (avail_w < to_end) ? avail_w : to_end;
    grant   = (req < lim) ? req : lim;
  end
endmodule

// File: rtl/frame_ring_next.sv
module frame_ring_next
  import frame_ring_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter int MF_FRAMES = 16,
  localparam int CNT_W    = PTR_W + 1
) (
  input  ring_op_e         op,
  input  logic [CNT_W-1:0] req,
  input  logic [PTR_W-1:0] wr_cmt,
  input  logic [PTR_W-1:0] wr_alc,
  input  logic [PTR_W-1:0] rd_pk,
  input  logic [PTR_W-1:0] rd_dis,
  input  logic [PTR_W-1:0] lv_unseen,
  input  logic [PTR_W-1:0] lv_free,
  input  logic [PTR_W-1:0] wr_pend,
  input  logic [PTR_W-1:0] rd_pend,
  output logic             ok,
  output logic [CNT_W-1:0] frames,
  output logic [PTR_W-1:0] ofs_ptr,
  output logic [PTR_W-1:0] nx_wr_cmt,
  output logic [PTR_W-1:0] nx_wr_alc,
  output logic [PTR_W-1:0] nx_rd_pk,
  output logic [PTR_W-1:0] nx_rd_dis
);
  localparam logic [PTR_W-1:0] MF_P  = PTR_W'(MF_FRAMES);
  localparam logic [PTR_W-1:0] MF_LO = PTR_W'(MF_FRAMES - 1);
  localparam logic [CNT_W-1:0] MF_C  = CNT_W'(MF_FRAMES);

  logic [CNT_W-1:0] wr_grant;
  logic [CNT_W-1:0] rd_grant;
  logic [PTR_W-1:0] tail_al;
  logic [PTR_W-1:0] head_al;

  frame_ring_clamp #(.PTR_W(PTR_W)) u_wr_clamp (
    .req(req), .avail(lv_free), .ptr(wr_cmt), .grant(wr_grant)
  );
  frame_ring_clamp #(.PTR_W(PTR_W)) u_rd_clamp (
    .req(req), .avail(lv_unseen), .ptr(rd_pk), .grant(rd_grant)
  );

  always_comb begin
    tail_al   = wr_cmt & ~MF_LO;
    head_al   = (rd_pk + MF_LO) & ~MF_LO;
    ok        = 1'b0;
    frames    = '0;
    ofs_ptr   = '0;
    nx_wr_cmt = wr_cmt;
    nx_wr_alc = wr_alc;
    nx_rd_pk  = rd_pk;
    nx_rd_dis = rd_dis;
    unique case (op)
      OP_WR_RUN: if (wr_alc == wr_cmt && wr_grant != '0) begin
        ok        = 1'b1;
        frames    = wr_grant;
        ofs_ptr   = wr_cmt;
        nx_wr_cmt = wr_cmt + wr_grant[PTR_W-1:0];
        nx_wr_alc = wr_cmt + wr_grant[PTR_W-1:0];
      end
      OP_RD_RUN: if (rd_pk == rd_dis && rd_grant != '0) begin
        ok        = 1'b1;
        frames    = rd_grant;
        ofs_ptr   = rd_pk;
        nx_rd_pk  = rd_pk + rd_grant[PTR_W-1:0];
        nx_rd_dis = rd_pk + rd_grant[PTR_W-1:0];
      end
      OP_MF_RSV: if (lv_free >= MF_P) begin
        ok        = 1'b1;
        frames    = MF_C;
        ofs_ptr   = wr_alc;
        nx_wr_alc = wr_alc + MF_P;
      end
      OP_MF_CMT: if (wr_pend >= MF_P) begin
        ok        = 1'b1;
        frames    = MF_C;
        ofs_ptr   = wr_cmt;
        nx_wr_cmt = wr_cmt + MF_P;
      end
      OP_MF_LOOK: if (lv_unseen >= MF_P) begin
        ok        = 1'b1;
        frames    = MF_C;
        ofs_ptr   = rd_pk;
        nx_rd_pk  = rd_pk + MF_P;
      end
      OP_MF_REL: if (rd_pend >= MF_P) begin
        ok        = 1'b1;
        frames    = MF_C;
        ofs_ptr   = rd_dis;
        nx_rd_dis = rd_dis + MF_P;
      end
      OP_FL_TAIL: begin
        ok        = 1'b1;
        ofs_ptr   = tail_al;
        nx_rd_pk  = tail_al;
        nx_rd_dis = tail_al;
      end
      OP_FL_HEAD: begin
        ok        = 1'b1;
        ofs_ptr   = head_al;
        nx_wr_cmt = head_al;
        nx_wr_alc = head_al;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/frame_ring_ptr.sv
module frame_ring_ptr
  import frame_ring_pkg::*;
#(
  parameter int RING_FRAMES = 256,
  parameter int MF_FRAMES   = 16,
  parameter int BASE_OFS    = 0,
  parameter int OFS_W       = 10,
  localparam int PTR_W      = $clog2(RING_FRAMES),
  localparam int CNT_W      = PTR_W + 1,
  localparam int MF_SH      = $clog2(MF_FRAMES),
  localparam int MF_W       = OFS_W - MF_SH,
  localparam int WA_W       = OFS_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_frames,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [CNT_W-1:0] rsp_frames,
  output logic [OFS_W-1:0] rsp_ofs,
  output logic [MF_W-1:0]  rsp_mf_idx,
  output logic [WA_W-1:0]  rsp_word_addr,
  output logic [PTR_W-1:0] lvl_alloc,
  output logic [PTR_W-1:0] lvl_valid,
  output logic [PTR_W-1:0] lvl_unseen,
  output logic [PTR_W-1:0] lvl_free
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  logic [PTR_W-1:0] wr_cmt_q, wr_alc_q, rd_pk_q, rd_dis_q;
  logic [PTR_W-1:0] wr_cmt_d, wr_alc_d, rd_pk_d, rd_dis_d;
  logic [PTR_W-1:0] wr_pend, rd_pend, ofs_ptr;
  logic             nx_ok;
  logic [CNT_W-1:0] nx_frames;
  logic [OFS_W-1:0] nx_ofs;
  logic             ok_q;
  logic [CNT_W-1:0] frames_q;
  logic [OFS_W-1:0] ofs_q;
  logic             vld_q;
  logic [PTR_W-1:0] nw_cmt, nw_alc, nr_pk, nr_dis;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  frame_ring_levels #(.PTR_W(PTR_W)) u_levels (
    .wr_cmt(wr_cmt_q), .wr_alc(wr_alc_q), .rd_pk(rd_pk_q), .rd_dis(rd_dis_q),
    .lv_alloc(lvl_alloc), .lv_valid(lvl_valid), .lv_unseen(lvl_unseen),
    .lv_free(lvl_free), .wr_pend(wr_pend), .rd_pend(rd_pend)
  );

  frame_ring_next #(.PTR_W(PTR_W), .MF_FRAMES(MF_FRAMES)) u_next (
    .op(ring_op_e'(cmd_op)), .req(cmd_frames),
    .wr_cmt(wr_cmt_q), .wr_alc(wr_alc_q), .rd_pk(rd_pk_q), .rd_dis(rd_dis_q),
    .lv_unseen(lvl_unseen), .lv_free(lvl_free),
    .wr_pend(wr_pend), .rd_pend(rd_pend),
    .ok(nx_ok), .frames(nx_frames), .ofs_ptr(ofs_ptr),
    .nx_wr_cmt(nw_cmt), .nx_wr_alc(nw_alc), .nx_rd_pk(nr_pk), .nx_rd_dis(nr_dis)
  );

  // next-state selection with explicit enable
  always_comb begin
    nx_ofs   = nx_ok ? (OFS_W'(BASE_OFS) + {{(OFS_W-PTR_W){1'b0}}, ofs_ptr}) : '0;
    wr_cmt_d = wr_cmt_q;
    wr_alc_d = wr_alc_q;
    rd_pk_d  = rd_pk_q;
    rd_dis_d = rd_dis_q;
    if (cmd_valid && nx_ok) begin
      wr_cmt_d = nw_cmt;
      wr_alc_d = nw_alc;
      rd_pk_d  = nr_pk;
      rd_dis_d = nr_dis;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_cmt_q <= '0;
      wr_alc_q <= '0;
      rd_pk_q  <= '0;
      rd_dis_q <= '0;
      vld_q    <= 1'b0;
      ok_q     <= 1'b0;
      frames_q <= '0;
      ofs_q    <= '0;
    end else begin
      wr_cmt_q <= wr_cmt_d;
      wr_alc_q <= wr_alc_d;
      rd_pk_q  <= rd_pk_d;
      rd_dis_q <= rd_dis_d;
      vld_q    <= cmd_valid;
      if (cmd_valid) begin
        ok_q     <= nx_ok;
        frames_q <= nx_frames;
        ofs_q    <= nx_ofs;
      end
    end
  end

  assign rsp_valid     = vld_q;
  assign rsp_ok        = ok_q;
  assign rsp_frames    = frames_q;
  assign rsp_ofs       = ofs_q;
  assign rsp_mf_idx    = MF_W'(ofs_q >> MF_SH);
  assign rsp_word_addr = {ofs_q, 3'b000};
endmodule

// File: rtl/frame_ring_ptr_chk.sv
module frame_ring_ptr_chk #(
  parameter int PTR_W     = 8,
  parameter int MF_FRAMES = 16,
  localparam int CNT_W    = PTR_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic [CNT_W-1:0] rsp_frames,
  input logic [PTR_W-1:0] lvl_alloc,
  input logic [PTR_W-1:0] lvl_valid,
  input logic [PTR_W-1:0] lvl_unseen,
  input logic [PTR_W-1:0] lvl_free
);
  localparam logic [PTR_W-1:0] FULL_SUM = {PTR_W{1'b1}};

  // R3: one slot always unused
  a_r3_free_alloc_sum: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(lvl_free + lvl_alloc) == FULL_SUM);

  // R2: ordering of the levels
  a_r2_level_order: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_unseen <= lvl_valid) && (lvl_valid <= lvl_alloc));

  // R4: a response follows each accepted command
  a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  // R11: a refused command leaves the levels untouched
  a_r11_refuse_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid ##1 (rsp_valid && !rsp_ok)) |->
      ($stable(lvl_alloc) && $stable(lvl_valid) && $stable(lvl_unseen)));

  // R5: a granted reserve grows the allocated level by one multiframe
  a_r5_reserve_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) ##1 rsp_ok |->
      (rsp_frames == CNT_W'(MF_FRAMES)) &&
      (lvl_alloc == PTR_W'($past(lvl_alloc) + PTR_W'(MF_FRAMES))));

  // R12: no command, no response
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
endmodule

bind frame_ring_ptr frame_ring_ptr_chk #(.PTR_W(PTR_W), .MF_FRAMES(MF_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_frames(rsp_frames),
  .lvl_alloc(lvl_alloc), .lvl_valid(lvl_valid), .lvl_unseen(lvl_unseen),
  .lvl_free(lvl_free)
);

// File: tb/frame_ring_ptr_tb.sv
module frame_ring_ptr_tb_top;
  // vector: op(3) req(9) ok(1) frames(9) ofs(10) alloc(8) valid(8) unseen(8) free(8)
  localparam int NV = 26;
  localparam logic [63:0] VEC [NV] = '{
    {3'd4, 9'd0,   1'b0, 9'd0,   10'd0,   8'd0,   8'd0,   8'd0,   8'd255},
    {3'd3, 9'd0,   1'b0, 9'd0,   10'd0,   8'd0,   8'd0,   8'd0,   8'd255},
    {3'd2, 9'd0,   1'b1, 9'd16,  10'd256, 8'd16,  8'd0,   8'd0,   8'd239},
    {3'd2, 9'd0,   1'b1, 9'd16,  10'd272, 8'd32,  8'd0,   8'd0,   8'd223},
    {3'd3, 9'd0,   1'b1, 9'd16,  10'd256, 8'd32,  8'd16,  8'd16,  8'd223},
    {3'd0, 9'd5,   1'b0, 9'd0,   10'd0,   8'd32,  8'd16,  8'd16,  8'd223},
    {3'd3, 9'd0,   1'b1, 9'd16,  10'd272, 8'd32,  8'd32,  8'd32,  8'd223},
    {3'd4, 9'd0,   1'b1, 9'd16,  10'd256, 8'd32,  8'd32,  8'd16,  8'd223},
    {3'd1, 9'd3,   1'b0, 9'd0,   10'd0,   8'd32,  8'd32,  8'd16,  8'd223},
    {3'd5, 9'd0,   1'b1, 9'd16,  10'd256, 8'd16,  8'd16,  8'd16,  8'd239},
    {3'd5, 9'd0,   1'b0, 9'd0,   10'd0,   8'd16,  8'd16,  8'd16,  8'd239},
    {3'd1, 9'd20,  1'b1, 9'd16,  10'd272, 8'd0,   8'd0,   8'd0,   8'd255},
    {3'd0, 9'd300, 1'b1, 9'd224, 10'd288, 8'd224, 8'd224, 8'd224, 8'd31},
    {3'd0, 9'd40,  1'b1, 9'd31,  10'd256, 8'd255, 8'd255, 8'd255, 8'd0},
    {3'd0, 9'd1,   1'b0, 9'd0,   10'd0,   8'd255, 8'd255, 8'd255, 8'd0},
    {3'd2, 9'd0,   1'b0, 9'd0,   10'd0,   8'd255, 8'd255, 8'd255, 8'd0},
    {3'd7, 9'd0,   1'b1, 9'd0,   10'd288, 8'd0,   8'd0,   8'd0,   8'd255},
    {3'd0, 9'd7,   1'b1, 9'd7,   10'd288, 8'd7,   8'd7,   8'd7,   8'd248},
    {3'd6, 9'd0,   1'b1, 9'd0,   10'd288, 8'd7,   8'd7,   8'd7,   8'd248},
    {3'd7, 9'd0,   1'b1, 9'd0,   10'd288, 8'd0,   8'd0,   8'd0,   8'd255},
    {3'd1, 9'd1,   1'b0, 9'd0,   10'd0,   8'd0,   8'd0,   8'd0,   8'd255},
    {3'd0, 9'd0,   1'b0, 9'd0,   10'd0,   8'd0,   8'd0,   8'd0,   8'd255},
    {3'd0, 9'd5,   1'b1, 9'd5,   10'd288, 8'd5,   8'd5,   8'd5,   8'd250},
    {3'd1, 9'd3,   1'b1, 9'd3,   10'd288, 8'd2,   8'd2,   8'd2,   8'd253},
    {3'd7, 9'd0,   1'b1, 9'd0,   10'd304, 8'd13,  8'd13,  8'd13,  8'd242},
    {3'd6, 9'd0,   1'b1, 9'd0,   10'd304, 8'd0,   8'd0,   8'd0,   8'd255}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [8:0]  cmd_frames = '0;
  logic        rsp_valid, rsp_ok;
  logic [8:0]  rsp_frames;
  logic [9:0]  rsp_ofs;
  logic [5:0]  rsp_mf_idx;
  logic [12:0] rsp_word_addr;
  logic [7:0]  lvl_alloc, lvl_valid, lvl_unseen, lvl_free;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  frame_ring_ptr #(.BASE_OFS(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_frames(cmd_frames), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_frames(rsp_frames), .rsp_ofs(rsp_ofs), .rsp_mf_idx(rsp_mf_idx),
    .rsp_word_addr(rsp_word_addr), .lvl_alloc(lvl_alloc), .lvl_valid(lvl_valid),
    .lvl_unseen(lvl_unseen), .lvl_free(lvl_free)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_levels(input string tag, input logic [7:0] a, input logic [7:0] v,
                              input logic [7:0] u, input logic [7:0] f);
    check(tag, {32'd0, lvl_alloc, lvl_valid, lvl_unseen, lvl_free}, {32'd0, a, v, u, f});
  endtask

  function automatic string op_tag(input logic [2:0] op, input logic ok);
    case (op)
      3'd0, 3'd1: return ok ? "R7 run" : "R8/R11 run refused";
      3'd2, 3'd3: return ok ? "R5 reserve/commit" : "R11 reserve/commit refused";
      3'd4, 3'd5: return ok ? "R6 look/release" : "R11 look/release refused";
      3'd6:       return "R9 flush tail";
      default:    return "R10 flush head";
    endcase
  endfunction

  task automatic send(input logic [2:0] op, input logic [8:0] n);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_frames = n;
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: levels during reset
    check_levels("R1 in reset", 8'd0, 8'd0, 8'd0, 8'd255);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_levels("R1 after release", 8'd0, 8'd0, 8'd0, 8'd255);
    check("R1 no response", {63'd0, rsp_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      logic [9:0]  eo;
      v = VEC[i];
      eo = v[41:32];
      send(v[63:61], v[60:52]);
      check({op_tag(v[63:61], v[51]), " R4 response"},
            {40'd0, rsp_valid, rsp_ok, rsp_frames, 3'd0, rsp_ofs},
            {40'd0, 1'b1, v[51], v[50:42], 3'd0, eo});
      check("R2 levels", {32'd0, lvl_alloc, lvl_valid, lvl_unseen, lvl_free}, {32'd0, v[31:0]});
      check("R3 free+alloc", {56'd0, 8'(lvl_free + lvl_alloc)}, 64'd255);
      if (v[51])
        check("R4 mf index/word address", {45'd0, rsp_mf_idx, rsp_word_addr},
              {45'd0, 6'(eo >> 4), {eo, 3'b000}});
    end

    // R12: command held without cmd_valid has no effect
    @(negedge clk);
    cmd_op = 3'd0; cmd_frames = 9'd9; cmd_valid = 1'b0;
    @(negedge clk);
    check("R12 no response", {63'd0, rsp_valid}, 64'd0);
    check_levels("R12 levels kept", 8'd0, 8'd0, 8'd0, 8'd255);

    // fill then reset mid-run
    send(3'd0, 9'd9);
    check_levels("R7 before reset", 8'd9, 8'd9, 8'd9, 8'd246);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_levels("R1 mid-run reset", 8'd0, 8'd0, 8'd0, 8'd255);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rsp low", {63'd0, rsp_valid}, 64'd0);
    send(3'd2, 9'd0);
    check("R5 reserve after reset", {54'd0, rsp_ok, rsp_frames}, {54'd0, 1'b1, 9'd16});
    check("R4 offset after reset", {54'd0, rsp_ofs}, 64'd256);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule